// File: doc/BRIEF.md
# Serial Time-Slot Control Decoder and Filter Coefficient Loader

This block sits behind a serial port that delivers four 16-bit slots per frame from a host signal processor. Slot 0 of every frame is a control word. That word can update one of four 8-bit configuration registers. It also selects either coefficient loading or sample transfer for the other three slots of the frame. In coefficient loading, the other slots are written in sequence into one of three 38-entry coefficient memories. In sample transfer, slot 1 and slot 2 are passed out as the transmit sample and an auxiliary sample.

Input beats arrive on a valid/ready stream. One beat is one slot word together with its slot index. The block never applies back-pressure: `in_ready` is held high, so every cycle with `in_valid` high is one accepted beat. Every output is registered. An output caused by a beat is visible for exactly one cycle, the cycle after the beat's accepting clock edge. The register and memory write strobes, and the sample outputs, are plain single-cycle pulses with no handshake.

Control word fields, by bit position:
- bit 15: 1 selects coefficient loading, 0 selects sample transfer.
- bit 14: restart flag.
- bit 13: clock choice.
- bits 12:11: memory pick.
- bits 10:8: register pick.
- bits 7:0: register value.

Top module: `tsl_coef_loader`

## Requirements
- R1: A beat on slot 0 is latched as the control word for the slots that follow. `clk_sel` takes the value of bit 13 of the most recent control word, and it is 0 after reset.
- R2: A control word whose register pick (bits 10:8) is n, with n from 0 to 3, pulses `reg_we[n]` with `reg_wdata` = bits 7:0, whatever the mode bit says. Picks 4 to 7 write no register.
- R3: Memory pick 00, 01 and 10 route coefficient writes to `ram_we[0]`, `ram_we[1]` and `ram_we[2]`. Pick 11 writes no memory. At most one `ram_we` bit is high in any cycle.
- R4: A control word with bit 15 and bit 14 set, and a memory pick other than 11, resets the word address to 0. In that frame, slot 1 is ignored, and slots 2 and 3 write addresses 0 and 1.
- R5: In the loading frames that follow, slots 1, 2 and 3 each write the next consecutive address, with `ram_wdata` equal to the slot word.
- R6: Once address 37 has been written, coefficient slots write nothing until the next restart. Coefficient slots that arrive after reset and before any restart also write nothing.
- R7: `ram_done[i]` rises in the cycle of the write to address 37 of memory i. It stays high until a restart that targets memory i.
- R8: When bit 15 is 0, slot 1 appears on `tx_sample` with a `tx_valid` pulse, and slot 2 appears on `aux_sample` with an `aux_valid` pulse. Slot 3 has no effect, and no memory is written.
- R9: `in_ready` is always high. After reset, every strobe, `ram_done` and `clk_sel` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Slot beat valid |
| in_ready | output | 1 | Always 1; beats are never stalled |
| in_slot | input | 2 | Slot index 0..3 |
| in_word | input | 16 | Slot word |
| reg_we | output | 4 | One-hot configuration register write pulse |
| reg_wdata | output | 8 | Configuration register value |
| clk_sel | output | 1 | Clock choice from the latest control word |
| ram_we | output | 3 | Coefficient memory write pulses |
| ram_addr | output | 6 | Coefficient word address |
| ram_wdata | output | 16 | Coefficient word |
| ram_done | output | 3 | Per-memory full-load flag |
| tx_valid | output | 1 | Transmit sample pulse |
| tx_sample | output | 16 | Transmit sample |
| aux_valid | output | 1 | Auxiliary sample pulse |
| aux_sample | output | 16 | Auxiliary sample |

## Verification
A short table of frames drives the following cases:
- a register write together with a memory pick of 11;
- a restart frame, whose ignored slot 1 separates restart handling from ordinary loading;
- a continuation frame that also writes a register, showing that both happen in the same frame;
- a sample-transfer frame between two loads.

A full 38-word load of the second memory, followed by an extra frame, shows where the address counter stops and when the done flag rises and clears. The following directed patterns each expose one decode confusion:
- coefficient slots sent before any restart;
- register picks 4 to 6;
- a register write in sample mode;
- slot 3 in sample mode.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int WORD_W = 16;
  localparam int REGV_W = 8;

  typedef struct packed {
    logic       coef_mode;
    logic       restart;
    logic       clk_pick;
    logic [1:0] ram_pick;
    logic [2:0] reg_pick;
    logic [7:0] reg_val;
  } ctrl_word_t;

  localparam ctrl_word_t CTRL_IDLE = '{coef_mode: 1'b0, restart: 1'b0, clk_pick: 1'b0,
                                       ram_pick: 2'b11, reg_pick: 3'b111, reg_val: 8'h00};
endpackage

// File: rtl/tsl_ctrl_decode.sv
module tsl_ctrl_decode
  import tsl_pkg::*;
#(
  parameter int NUM_REG = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             in_slot,
  input  logic [WORD_W-1:0]      in_word,
  output logic                   ctrl_evt,
  output ctrl_word_t             ctrl_next,
  output ctrl_word_t             ctrl_q,
  output logic [NUM_REG-1:0]     reg_we,
  output logic [REGV_W-1:0]      reg_wdata,
  output logic                   clk_sel
);
  logic [NUM_REG-1:0] we_d;

  assign ctrl_evt  = in_valid && (in_slot == 2'd0);
  assign ctrl_next = ctrl_word_t'(in_word);

  for (genvar i = 0; i < NUM_REG; i++) begin : g_we
    assign we_d[i] = ctrl_evt && (int'(ctrl_next.reg_pick) == i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_IDLE;
      reg_we    <= '0;
      reg_wdata <= '0;
      clk_sel   <= 1'b0;
    end else begin
      reg_we <= we_d;
      if (ctrl_evt) begin
        ctrl_q    <= ctrl_next;
        reg_wdata <= ctrl_next.reg_val;
        clk_sel   <= ctrl_next.clk_pick;
      end
    end
  end

  // R2: register strobes are one-hot or idle
  p_reg_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reg_we));
  // R2: a register write only follows a control beat
  p_reg_after_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_we) |-> $past(ctrl_evt));
endmodule

// File: rtl/tsl_coef_addr.sv
module tsl_coef_addr
  import tsl_pkg::*;
#(
  parameter int DEPTH   = 38,
  parameter int NUM_RAM = 3,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            in_slot,
  input  logic [WORD_W-1:0]     in_word,
  input  logic                  ctrl_evt,
  input  ctrl_word_t            ctrl_next,
  input  ctrl_word_t            ctrl_q,
  output logic [NUM_RAM-1:0]    ram_we,
  output logic [ADDR_W-1:0]     ram_addr,
  output logic [WORD_W-1:0]     ram_wdata,
  output logic [NUM_RAM-1:0]    ram_done
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic start_evt, coef_beat;

  assign start_evt = ctrl_evt && ctrl_next.coef_mode && ctrl_next.restart &&
                     (int'(ctrl_next.ram_pick) < NUM_RAM);
  assign coef_beat = in_valid && (in_slot != 2'd0) && ctrl_q.coef_mode &&
                     (int'(ctrl_q.ram_pick) < NUM_RAM) &&
                     !(ctrl_q.restart && in_slot == 2'd1) && (cnt_q < CNT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_END;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      if (start_evt)      cnt_q <= '0;
      else if (coef_beat) cnt_q <= cnt_q + 1'b1;
      if (coef_beat) begin
        ram_addr  <= cnt_q[ADDR_W-1:0];
        ram_wdata <= in_word;
      end
    end
  end

  for (genvar i = 0; i < NUM_RAM; i++) begin : g_ram
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ram_we[i]   <= 1'b0;
        ram_done[i] <= 1'b0;
      end else begin
        ram_we[i] <= coef_beat && (int'(ctrl_q.ram_pick) == i);
        if (start_evt && int'(ctrl_next.ram_pick) == i)
          ram_done[i] <= 1'b0;
        else if (coef_beat && cnt_q == CNT_LAST && int'(ctrl_q.ram_pick) == i)
          ram_done[i] <= 1'b1;
      end
    end
  end

  // R3: one memory at a time
  p_ram_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ram_we));
  // R6: address never passes the last entry
  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ram_we) |-> (int'(ram_addr) < DEPTH));
  // R5: back-to-back writes without restart step the address by one
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ram_we) && coef_beat && !start_evt) |=> (ram_addr == $past(ram_addr) + 1'b1));
  // R7: done flags only drop on a restart
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> ((ram_done & $past(ram_done)) == $past(ram_done)));
endmodule

// File: rtl/tsl_data_demux.sv
module tsl_data_demux
  import tsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_slot,
  input  logic [WORD_W-1:0] in_word,
  input  ctrl_word_t        ctrl_q,
  output logic              tx_valid,
  output logic [WORD_W-1:0] tx_sample,
  output logic              aux_valid,
  output logic [WORD_W-1:0] aux_sample
);
  logic data_beat;
  assign data_beat = in_valid && !ctrl_q.coef_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid   <= 1'b0;
      aux_valid  <= 1'b0;
      tx_sample  <= '0;
      aux_sample <= '0;
    end else begin
      tx_valid  <= data_beat && in_slot == 2'd1;
      aux_valid <= data_beat && in_slot == 2'd2;
      if (data_beat && in_slot == 2'd1) tx_sample  <= in_word;
      if (data_beat && in_slot == 2'd2) aux_sample <= in_word;
    end
  end

  // R8: the two sample pulses never coincide
  p_sample_excl_r8: assert property (@(posedge clk) disable iff (!rst_n) !(tx_valid && aux_valid));
endmodule

// File: rtl/tsl_coef_loader.sv
module tsl_coef_loader
  import tsl_pkg::*;
#(
  parameter int DEPTH   = 38,
  parameter int NUM_RAM = 3,
  parameter int NUM_REG = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          in_slot,
  input  logic [WORD_W-1:0]   in_word,
  output logic [NUM_REG-1:0]  reg_we,
  output logic [REGV_W-1:0]   reg_wdata,
  output logic                clk_sel,
  output logic [NUM_RAM-1:0]  ram_we,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [WORD_W-1:0]   ram_wdata,
  output logic [NUM_RAM-1:0]  ram_done,
  output logic                tx_valid,
  output logic [WORD_W-1:0]   tx_sample,
  output logic                aux_valid,
  output logic [WORD_W-1:0]   aux_sample
);
  logic       ctrl_evt;
  ctrl_word_t ctrl_next, ctrl_q;

  assign in_ready = 1'b1;

  tsl_ctrl_decode #(.NUM_REG(NUM_REG)) u_dec (
    .clk, .rst_n, .in_valid, .in_slot, .in_word,
    .ctrl_evt, .ctrl_next, .ctrl_q, .reg_we, .reg_wdata, .clk_sel
  );

  tsl_coef_addr #(.DEPTH(DEPTH), .NUM_RAM(NUM_RAM)) u_addr (
    .clk, .rst_n, .in_valid, .in_slot, .in_word,
    .ctrl_evt, .ctrl_next, .ctrl_q, .ram_we, .ram_addr, .ram_wdata, .ram_done
  );

  tsl_data_demux u_demux (
    .clk, .rst_n, .in_valid, .in_slot, .in_word, .ctrl_q,
    .tx_valid, .tx_sample, .aux_valid, .aux_sample
  );

  // R8: a sample pulse never coincides with a memory write
  p_data_no_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || aux_valid) |-> (ram_we == '0));
endmodule

// File: tb/tsl_coef_loader_bench.sv
module tsl_coef_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_slot = '0;
  logic [15:0] in_word = '0;
  logic [3:0]  reg_we;
  logic [7:0]  reg_wdata;
  logic        clk_sel;
  logic [2:0]  ram_we;
  logic [5:0]  ram_addr;
  logic [15:0] ram_wdata;
  logic [2:0]  ram_done;
  logic        tx_valid, aux_valid;
  logic [15:0] tx_sample, aux_sample;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tsl_coef_loader u_tsl_coef_loader (
    .clk, .rst_n, .in_valid, .in_ready, .in_slot, .in_word,
    .reg_we, .reg_wdata, .clk_sel, .ram_we, .ram_addr, .ram_wdata, .ram_done,
    .tx_valid, .tx_sample, .aux_valid, .aux_sample
  );

  // {slot, word, expected ram_we, expected addr, expected reg_we}
  localparam int NV = 14;
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 16'hB9A4, 3'b000, 6'd0, 4'b0010},
    {2'd1, 16'h1234, 3'b000, 6'd0, 4'b0000},
    {2'd0, 16'hE0F1, 3'b000, 6'd0, 4'b0001},
    {2'd1, 16'hFFFF, 3'b000, 6'd0, 4'b0000},
    {2'd2, 16'h0011, 3'b001, 6'd0, 4'b0000},
    {2'd3, 16'h0022, 3'b001, 6'd1, 4'b0000},
    {2'd0, 16'hA340, 3'b000, 6'd0, 4'b1000},
    {2'd1, 16'hA000, 3'b001, 6'd2, 4'b0000},
    {2'd2, 16'h0033, 3'b001, 6'd3, 4'b0000},
    {2'd3, 16'h0044, 3'b001, 6'd4, 4'b0000},
    {2'd0, 16'h3FFF, 3'b000, 6'd0, 4'b0000},
    {2'd1, 16'h4444, 3'b000, 6'd0, 4'b0000},
    {2'd0, 16'hF7FF, 3'b000, 6'd0, 4'b0000},
    {2'd2, 16'h5555, 3'b100, 6'd0, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] s, input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_slot = s; in_word = w;
    @(posedge clk);
    #1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 ready", 32'(in_ready), 1);
    chk("R9 reg_we", 32'(reg_we), 0);
    chk("R9 ram_we", 32'(ram_we), 0);
    chk("R9 done", 32'(ram_done), 0);
    chk("R1 clk_sel reset", 32'(clk_sel), 0);
    chk("R9 tx_valid", 32'(tx_valid), 0);
    @(negedge clk) rst_n = 1'b1;

    // R6: loading slots before any restart write nothing
    send(2'd0, 16'hA7FF);
    send(2'd1, 16'h7777);
    chk("R6 idle before restart", 32'(ram_we), 0);
    send(2'd2, 16'h7778);
    chk("R6 idle before restart", 32'(ram_we), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      @(negedge clk);
      in_valid = 1'b1; in_slot = v[30:29]; in_word = v[28:13];
      @(posedge clk);
      #1;
      chk("R3 R4 ram_we", 32'(ram_we), 32'(v[12:10]));
      if (v[12:10] != 3'b000) begin
        chk("R5 addr", 32'(ram_addr), 32'(v[9:4]));
        chk("R5 wdata", 32'(ram_wdata), 32'(v[28:13]));
      end
      chk("R2 reg_we", 32'(reg_we), 32'(v[3:0]));
      if (v[3:0] != 4'b0000) chk("R2 reg_wdata", 32'(reg_wdata), 32'(v[20:13]));
      if (v[30:29] == 2'd0) chk("R1 clk_sel", 32'(clk_sel), 32'(v[26]));
      @(negedge clk);
      in_valid = 1'b0;
    end

    // R2: picks 4..6 write nothing; register write in sample mode
    for (int p = 4; p < 7; p++) begin
      @(negedge clk);
      in_valid = 1'b1; in_slot = 2'd0; in_word = {5'b10000, 3'(p), 8'h55};
      @(posedge clk); #1;
      chk("R2 no write for pick 4..6", 32'(reg_we), 0);
      chk("R1 clk_sel low", 32'(clk_sel), 0);
      @(negedge clk) in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_slot = 2'd0; in_word = 16'h0255;
    @(posedge clk); #1;
    chk("R2 write in sample mode", 32'(reg_we), 32'h4);
    chk("R2 wdata in sample mode", 32'(reg_wdata), 32'h55);
    @(negedge clk) in_valid = 1'b0;

    // R8: sample transfer
    send(2'd0, 16'h3FFF);
    @(negedge clk);
    in_valid = 1'b1; in_slot = 2'd1; in_word = 16'h1111;
    @(posedge clk); #1;
    chk("R8 tx_valid", 32'(tx_valid), 1);
    chk("R8 tx_sample", 32'(tx_sample), 32'h1111);
    chk("R8 no ram write", 32'(ram_we), 0);
    @(negedge clk) in_slot = 2'd2; in_word = 16'h2222;
    @(posedge clk); #1;
    chk("R8 aux_valid", 32'(aux_valid), 1);
    chk("R8 aux_sample", 32'(aux_sample), 32'h2222);
    chk("R8 tx pulse ends", 32'(tx_valid), 0);
    @(negedge clk) in_slot = 2'd3; in_word = 16'h3333;
    @(posedge clk); #1;
    chk("R8 slot3 no tx", 32'(tx_valid), 0);
    chk("R8 slot3 no aux", 32'(aux_valid), 0);
    chk("R8 slot3 sample kept", 32'(tx_sample), 32'h1111);
    chk("R8 slot3 no ram", 32'(ram_we), 0);
    @(negedge clk) in_valid = 1'b0;

    // R4 R5 R6 R7: full load of memory 2
    begin
      int exp_addr;
      exp_addr = 0;
      send(2'd0, 16'hEFFF);
      chk("R7 done clear at start", 32'(ram_done[1]), 0);
      for (int f = 0; f < 13; f++) begin
        if (f > 0) send(2'd0, 16'hAFFF);
        for (int s = 1; s < 4; s++) begin
          @(negedge clk);
          in_valid = 1'b1; in_slot = 2'(s); in_word = 16'(16'h0100 + f * 4 + s);
          @(posedge clk); #1;
          if (f == 0 && s == 1) begin
            chk("R4 slot1 ignored", 32'(ram_we), 0);
          end else begin
            chk("R3 ram2 we", 32'(ram_we), 32'b010);
            chk("R5 seq addr", 32'(ram_addr), 32'(exp_addr));
            chk("R7 done timing", 32'(ram_done[1]), (exp_addr == 37) ? 1 : 0);
            exp_addr++;
          end
          @(negedge clk) in_valid = 1'b0;
        end
      end
      send(2'd0, 16'hAFFF);
      @(negedge clk);
      in_valid = 1'b1; in_slot = 2'd1; in_word = 16'hDEAD;
      @(posedge clk); #1;
      chk("R6 no write past end", 32'(ram_we), 0);
      chk("R7 done holds", 32'(ram_done), 32'b010);
      @(negedge clk) in_valid = 1'b0;
      send(2'd0, 16'hEFFF);
      chk("R7 done cleared by restart", 32'(ram_done[1]), 0);
      send(2'd2, 16'hBEEF);
      chk("R4 restart addr 0", 32'(ram_addr), 0);
      chk("R4 restart we", 32'(ram_we), 32'b010);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule